// File: doc/BRIEF.md
# DRAM Wake Recovery Sequencer

This block brings DRAM back into service after a system sleep. During the sleep the devices keep their contents by refreshing themselves, and the controller state is lost. When `wake_req` is sampled high, the sequencer raises the clock-enable line. It holds the exit step for a repeated slot count, then drives NOP commands for a minimum settling time. That time is given in picoseconds and is turned into whole cycles, rounding up.

The block then sends a back-to-back burst of AUTO REFRESH commands, one for each row. Every refresh is followed by a fixed gap of NOP cycles that covers the refresh recovery time. Only when the whole burst is finished does it raise the periodic-refresh enable. A ready flag follows one cycle later. After that the sequencer stays where it is until reset, and ignores any further wake request.

Top module: `sr_wake_seq`

## Requirements
- R1: While reset is held, and afterwards until a wake request is sampled, `cke` is 0, `cmd` is DESELECT (4'b1111, bits {cs_n, ras_n, cas_n, we_n}), and `refresh_en` and `ready` are 0.
- R2: In the cycle after the clock edge that samples `wake_req` high, `cke` goes to 1 and stays 1 until reset. The first EXIT_REPEATS cycles with `cke` high (default 2) carry DESELECT.
- R3: After the exit cycles, `cmd` is NOP (4'b0111) for exactly NOP_CYC = ceil(NOP_PS / CLK_PS) cycles.
- R4: Exactly ROWS AUTO REFRESH commands (4'b0001) are issued, one cycle each. The first one comes in the cycle right after the NOP window.
- R5: Every AUTO REFRESH is followed by exactly TRFC_CYC NOP cycles, including the last one, so no two refreshes are ever closer than TRFC_CYC + 1 cycles.
- R6: `refresh_en` is 0 until the gap after the last refresh has elapsed. It rises EXIT_REPEATS + NOP_CYC + ROWS*(TRFC_CYC+1) cycles after `cke` rises, then stays 1 while `cmd` stays NOP.
- R7: `ready` rises exactly one cycle after `refresh_en` and stays 1.
- R8: A wake request sampled while the sequence is running, or after it has finished, has no effect: the timeline is unchanged and the outputs keep their values until reset.
- R9: Parameters are checked when the design is elaborated: ROWS, TRFC_CYC, EXIT_REPEATS, CLK_PS and NOP_PS must all be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 1 | Request to leave self-refresh |
| cke | output | 1 | DRAM clock enable |
| cmd | output | 4 | Command bus {cs_n, ras_n, cas_n, we_n} |
| refresh_en | output | 1 | Periodic refresh enable |
| ready | output | 1 | DRAM usable, one cycle after refresh_en |

## Verification
Two things can coincide in one cycle. The first is the last gap NOP expiring while the burst counter reaches zero; that cycle must lead to the enable and not to another refresh. The second is a wake request arriving while the sequence is already running or has finished. The bench provokes both by holding `wake_req` high for an entire run and by pulsing it after `ready`. It judges the results against a table of timed checkpoints, an exact count of refreshes, and the stability of the outputs.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      SRX_SLEEP,
      SRX_EXIT,
      SRX_SETTLE,
      SRX_AREF,
      SRX_GAP,
      SRX_LIVE
   } srx_state_e;

   // command bus bit order: {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_DESEL = 4'b1111;
   localparam logic [3:0] CMD_NOP   = 4'b0111;
   localparam logic [3:0] CMD_AREF  = 4'b0001;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/srx_down_ctr.sv
module srx_down_ctr #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         zero
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (dec && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/srx_cmd_enc.sv
module srx_cmd_enc
   import srx_pkg::*;
(
   input  srx_state_e state,
   output logic       cke,
   output logic [3:0] cmd,
   output logic       refresh_en
);

   always_comb begin
      cke        = 1'b1;
      cmd        = CMD_NOP;
      refresh_en = 1'b0;
      unique case (state)
         SRX_SLEEP: begin
            cke = 1'b0;
            cmd = CMD_DESEL;
         end
         SRX_EXIT:   cmd = CMD_DESEL;
         SRX_SETTLE: cmd = CMD_NOP;
         SRX_AREF:   cmd = CMD_AREF;
         SRX_GAP:    cmd = CMD_NOP;
         SRX_LIVE:   refresh_en = 1'b1;
         default: begin
            cke = 1'b0;
            cmd = CMD_DESEL;
         end
      endcase
   end

endmodule

// File: rtl/sr_wake_seq.sv
module sr_wake_seq
   import srx_pkg::*;
#(
   parameter int unsigned CLK_PS       = 5000,
   parameter int unsigned NOP_PS       = 80000,
   parameter int unsigned ROWS         = 8192,
   parameter int unsigned TRFC_CYC     = 26,
   parameter int unsigned EXIT_REPEATS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wake_req,
   output logic       cke,
   output logic [3:0] cmd,
   output logic       refresh_en,
   output logic       ready
);

   localparam int unsigned NOP_CYC = ceil_div(NOP_PS, CLK_PS);
   localparam int unsigned TMAX    = max3(EXIT_REPEATS, NOP_CYC, TRFC_CYC);
   localparam int unsigned TW      = $clog2(TMAX + 1);
   localparam int unsigned BW      = $clog2(ROWS + 1);

   // elaboration-time parameter checks (R9)
   generate
      if (ROWS < 1) begin : g_bad_rows
         $error("sr_wake_seq: ROWS must be at least 1");
      end
      if (TRFC_CYC < 1) begin : g_bad_trfc
         $error("sr_wake_seq: TRFC_CYC must be at least 1");
      end
      if (EXIT_REPEATS < 1) begin : g_bad_exit
         $error("sr_wake_seq: EXIT_REPEATS must be at least 1");
      end
      if ((CLK_PS < 1) || (NOP_PS < 1)) begin : g_bad_time
         $error("sr_wake_seq: CLK_PS and NOP_PS must be at least 1");
      end
   endgenerate

   srx_state_e     st_q, st_d;
   logic           tmr_load, tmr_dec, tmr_zero;
   logic [TW-1:0]  tmr_val, tmr_cnt;
   logic           bst_load, bst_dec, bst_zero;
   logic [BW-1:0]  bst_cnt;
   logic           ref_en_w;

   srx_down_ctr #(.W(TW)) u_phase_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .dec      (tmr_dec),
      .cnt      (tmr_cnt),
      .zero     (tmr_zero)
   );

   srx_down_ctr #(.W(BW)) u_burst_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (bst_load),
      .load_val (BW'(ROWS)),
      .dec      (bst_dec),
      .cnt      (bst_cnt),
      .zero     (bst_zero)
   );

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      tmr_dec  = 1'b0;
      bst_load = 1'b0;
      bst_dec  = 1'b0;
      unique case (st_q)
         SRX_SLEEP: begin
            if (wake_req) begin
               st_d     = SRX_EXIT;
               tmr_load = 1'b1;
               tmr_val  = TW'(EXIT_REPEATS - 1);
               bst_load = 1'b1;
            end
         end
         SRX_EXIT: begin
            if (tmr_zero) begin
               st_d     = SRX_SETTLE;
               tmr_load = 1'b1;
               tmr_val  = TW'(NOP_CYC - 1);
            end else begin
               tmr_dec = 1'b1;
            end
         end
         SRX_SETTLE: begin
            if (tmr_zero) st_d = SRX_AREF;
            else          tmr_dec = 1'b1;
         end
         SRX_AREF: begin
            bst_dec  = 1'b1;
            st_d     = SRX_GAP;
            tmr_load = 1'b1;
            tmr_val  = TW'(TRFC_CYC - 1);
         end
         SRX_GAP: begin
            if (tmr_zero) st_d = bst_zero ? SRX_LIVE : SRX_AREF;
            else          tmr_dec = 1'b1;
         end
         SRX_LIVE: st_d = SRX_LIVE;
         default:  st_d = SRX_SLEEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SRX_SLEEP;
      else        st_q <= st_d;
   end

   srx_cmd_enc u_enc (
      .state      (st_q),
      .cke        (cke),
      .cmd        (cmd),
      .refresh_en (ref_en_w)
   );

   assign refresh_en = ref_en_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ready <= 1'b0;
      else        ready <= ref_en_w;
   end

endmodule

// File: rtl/sr_wake_seq_chk.sv
module sr_wake_seq_chk
   import srx_pkg::*;
#(
   parameter int unsigned ROWS     = 8192,
   parameter int unsigned TRFC_CYC = 26,
   parameter int unsigned NOP_CYC  = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cke,
   input logic [3:0] cmd,
   input logic       refresh_en,
   input logic       ready
);

   logic [31:0] refs_seen;
   logic [31:0] nop_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         refs_seen <= '0;
         nop_run   <= '0;
      end else begin
         if (cmd == CMD_AREF) refs_seen <= refs_seen + 1;
         if (cmd == CMD_NOP) nop_run <= (nop_run == '1) ? nop_run : nop_run + 1;
         else                nop_run <= '0;
      end
   end

   p_cke_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   p_settle_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_AREF && refs_seen == 0) |-> nop_run >= NOP_CYC);

   p_ref_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_en |-> refs_seen == ROWS);

   p_ref_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_AREF && refs_seen != 0) |-> nop_run >= TRFC_CYC);

   p_ref_then_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_AREF) |=> (cmd == CMD_NOP));

   p_ref_with_cke_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_AREF) |-> (cke && !refresh_en));

   p_enable_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_en |=> (refresh_en && cmd == CMD_NOP));

   p_ready_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_en |=> ready);

   p_ready_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !refresh_en |=> !ready);

endmodule

bind sr_wake_seq sr_wake_seq_chk #(
   .ROWS     (ROWS),
   .TRFC_CYC (TRFC_CYC),
   .NOP_CYC  (NOP_CYC)
) u_sr_wake_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cke        (cke),
   .cmd        (cmd),
   .refresh_en (refresh_en),
   .ready      (ready)
);

// File: tb/test_sr_wake_seq.sv
`timescale 1ns/1ps
module test_sr_wake_seq;

   // bench parameters: NOP_CYC = ceil(81000/5000) = 17 (round-up case)
   localparam int unsigned CLK_PS = 5000;
   localparam int unsigned NOP_PS = 81000;
   localparam int unsigned ROWS   = 5;
   localparam int unsigned TRFC   = 3;
   localparam int unsigned EXITN  = 2;
   localparam int unsigned NCYC   = 17;
   localparam int unsigned T_EN   = EXITN + NCYC + ROWS * (TRFC + 1); // 39
   localparam int unsigned T_END  = T_EN + 4;

   // checkpoint row: {t[7:0], cke, cmd[3:0], refresh_en, ready}
   localparam int NV = 15;
   localparam logic [14:0] VEC [NV] = '{
      {8'd0,  1'b1, 4'b1111, 1'b0, 1'b0},   // R2 exit slot 1
      {8'd1,  1'b1, 4'b1111, 1'b0, 1'b0},   // R2 exit slot 2
      {8'd2,  1'b1, 4'b0111, 1'b0, 1'b0},   // R3 first settle NOP
      {8'd18, 1'b1, 4'b0111, 1'b0, 1'b0},   // R3 last settle NOP
      {8'd19, 1'b1, 4'b0001, 1'b0, 1'b0},   // R4 first refresh
      {8'd20, 1'b1, 4'b0111, 1'b0, 1'b0},   // R5 gap
      {8'd22, 1'b1, 4'b0111, 1'b0, 1'b0},   // R5 gap end
      {8'd23, 1'b1, 4'b0001, 1'b0, 1'b0},   // R5 second refresh
      {8'd31, 1'b1, 4'b0001, 1'b0, 1'b0},   // R4 fourth refresh
      {8'd35, 1'b1, 4'b0001, 1'b0, 1'b0},   // R4 last refresh
      {8'd36, 1'b1, 4'b0111, 1'b0, 1'b0},   // R5 trailing gap
      {8'd38, 1'b1, 4'b0111, 1'b0, 1'b0},   // R6 still disabled
      {8'd39, 1'b1, 4'b0111, 1'b1, 1'b0},   // R6 enable rises
      {8'd40, 1'b1, 4'b0111, 1'b1, 1'b1},   // R7 ready rises
      {8'd43, 1'b1, 4'b0111, 1'b1, 1'b1}    // R7 ready holds
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wake_req = 1'b0;
   logic       cke;
   logic [3:0] cmd;
   logic       refresh_en;
   logic       ready;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   sr_wake_seq #(
      .CLK_PS(CLK_PS), .NOP_PS(NOP_PS), .ROWS(ROWS),
      .TRFC_CYC(TRFC), .EXIT_REPEATS(EXITN)
   ) i_sr_wake_seq (
      .clk(clk), .rst_n(rst_n), .wake_req(wake_req),
      .cke(cke), .cmd(cmd), .refresh_en(refresh_en), .ready(ready)
   );

   task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b (cke,cmd,en,rdy)", req, act, exp);
      end
   endtask

   task automatic do_reset();
      wake_req = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 in reset", {cke, cmd, refresh_en, ready}, 7'b0_1111_0_0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 idle after reset", {cke, cmd, refresh_en, ready}, 7'b0_1111_0_0);
   endtask

   // hold=1 keeps wake_req high across the whole run (R8)
   task automatic run_seq(input bit hold, input string tag);
      int refs = 0;
      @(negedge clk);
      wake_req = 1'b1;
      @(negedge clk);          // t = 0: first cycle after the sampling edge
      if (!hold) wake_req = 1'b0;
      for (int t = 0; t <= int'(T_END); t++) begin
         if (cmd == 4'b0001) refs++;
         for (int v = 0; v < NV; v++) begin
            if (int'(VEC[v][14:7]) == t)
               check(tag, {cke, cmd, refresh_en, ready}, VEC[v][6:0]);
         end
         @(negedge clk);
      end
      check({tag, " R4 refresh total"}, 7'(refs), 7'(ROWS));
      wake_req = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      run_seq(1'b0, "R2-table pulse");
      // late wake after completion must change nothing (R8)
      @(negedge clk);
      wake_req = 1'b1;
      repeat (3) @(negedge clk);
      wake_req = 1'b0;
      for (int k = 0; k < 6; k++) begin
         check("R8 wake after ready", {cke, cmd, refresh_en, ready}, 7'b1_0111_1_1);
         @(negedge clk);
      end
      // reset returns to sleep state (R1), then held wake gives same timeline (R8)
      do_reset();
      run_seq(1'b1, "R8 held wake");
      // wake held at reset release: sequencer leaves sleep on the first edge
      wake_req = 1'b1;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 reset overrides wake", {cke, cmd, refresh_en, ready}, 7'b0_1111_0_0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 exit after reset release", {cke, cmd, refresh_en, ready}, 7'b1_1111_0_0);
      wake_req = 1'b0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule